// File: doc/BRIEF.md
# Card Bus Clock Mode Generator

This block turns a requested card bus frequency, the frequency of the source clock and a timing-mode code into a complete clock setting: a 2-bit clock mode, a divider field, a half-rate flag for the fastest double-data-rate timing, and the bus frequency that the setting actually yields. It also drives the divided clock. This is a source-clock tick at the bus rate, used as a clock enable by the pad logic.

A change starts when `apply_i` is high and the requested frequency or timing code differs from the values stored by the last finished change. During the change the block saves the interrupt enables and masks them. It clears the half-rate flag and computes the divisor with a shared serial divider. It then applies the setting and waits a fixed number of source cycles for the clock to settle. After that it restores the saved enables and raises one-cycle `done_o` and `tmo_recalc_o` pulses. The timeout logic uses the `tmo_recalc_o` pulse to rescale its counts.

The timing codes are 0 for single data rate, 1 and 2 for the two 50 MHz-class double-data-rate timings, and 3 for the 200 MHz double-data-rate timing. The mode codes are 0 for single data rate with divisor, 1 for single data rate with no divisor, 2 for double data rate, and 3 for the 200 MHz double-data-rate timing.

Top module: `clk_cfg_top`

## Requirements
- R1: An `apply_i` pulse whose frequency and timing both equal the stored pair starts nothing: `busy_o` stays 0, no `done_o` appears, and all outputs keep their values. A change of either one alone starts a reconfiguration. The stored pair becomes the new request at `done_o`.
- R2: With timing 0 and a request at or above the source frequency, the result is mode 1, divider 0 and bus frequency equal to the source.
- R3: With timing 0 below the source frequency, N = ceil(src/(4*req)) is clipped to 1..255, and a request of 0 gives 255. The result is mode 0, divider N and bus frequency floor(floor(src/4)/N).
- R4: Timings 1 and 2 give mode 2 and timing 3 gives mode 3. In these modes a request at or above floor(src/4) gives divider 0 and bus frequency floor(src/4).
- R5: In modes 2 and 3 below floor(src/4), N is computed as in R3, the divider field is N shifted right by one, and the bus frequency is floor(floor(src/4)/N).
- R6: With timing 3 and a request at or above floor(src/2), `half_rate_o` is set, the divider is forced to 0 and the bus frequency is floor(src/2). The flag reads 0 in the first cycle of every reconfiguration.
- R7: At the start of a reconfiguration `irq_en_i` is saved. `irq_en_o` is 0 while `busy_o` is high and equals the saved value in the `done_o` cycle. When idle it follows `irq_en_i` one cycle late.
- R8: `clk_stable_o` is 0 from the first busy cycle until `STABLE_CYC` cycles after the setting is applied. `done_o` and `tmo_recalc_o` are single-cycle pulses in the cycle `clk_stable_o` rises, at least `STABLE_CYC`+1 cycles after the apply edge.
- R9: `card_tick_o` repeats every cycle in mode 1, every 2 cycles with the half-rate flag, every 4 cycles with divider 0 in modes 2 and 3, and every 4*N cycles otherwise.
- R10: After reset, mode, divider, half-rate flag, bus frequency, `clk_stable_o`, `irq_en_o` and `card_tick_o` are all 0, and the stored frequency and timing are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apply_i | input | 1 | Request a clock setting |
| req_hz_i | input | FW | Requested bus frequency in Hz |
| src_hz_i | input | FW | Source clock frequency in Hz |
| timing_i | input | 2 | Timing code (0 SDR, 1/2 DDR, 3 HS400-class) |
| irq_en_i | input | IW | Interrupt enables set by the host |
| mode_o | output | 2 | Applied clock mode |
| div_o | output | 8 | Applied divider field |
| half_rate_o | output | 1 | Half-rate override, divider ignored |
| bus_hz_o | output | FW | Resulting bus frequency |
| card_tick_o | output | 1 | One source-cycle tick per bus clock period |
| clk_stable_o | output | 1 | Bus clock settled |
| busy_o | output | 1 | Reconfiguration in progress |
| done_o | output | 1 | Reconfiguration finished (pulse) |
| tmo_recalc_o | output | 1 | Timeout recalculation request (pulse) |
| irq_en_o | output | IW | Interrupt enables as seen by the controller |

## Verification
Three paths set the latency. A request served by a threshold test reaches `done_o` exactly `STABLE_CYC`+1 cycles after the apply edge. A divided request adds two serial divisions of FW+3 steps each, so its latency is only bounded. The bench therefore samples on falling edges and follows each request until `done_o`. It checks `busy_o`, the masked enables and the cleared half-rate flag from the first falling edge onward, checks the setting in the `done_o` cycle, and then measures two consecutive `card_tick_o` edges to get the period.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  typedef enum logic [1:0] {
    TM_SDR   = 2'd0,
    TM_DDR50 = 2'd1,
    TM_DDR52 = 2'd2,
    TM_HS400 = 2'd3
  } timing_e;

  typedef enum logic [1:0] {
    MD_SDR_DIV  = 2'd0,
    MD_SDR_FULL = 2'd1,
    MD_DDR      = 2'd2,
    MD_HS400    = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC_N,
    ST_CALC_B,
    ST_APPLY,
    ST_SETTLE
  } state_e;
endpackage

// File: rtl/clk_cfg_divu.sv
module clk_cfg_divu #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, b_q, b_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;
  logic [W:0]    trial;
  logic          ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial >= {1'b0, b_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    b_d    = b_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      rem_d = '0;
      quo_d = a;
      b_d   = b;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? W'(trial - {1'b0, b_q}) : trial[W-1:0];
      quo_d = {quo_q[W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      b_q    <= b_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign q    = quo_q;
  assign done = done_q;
endmodule

// File: rtl/clk_cfg_tick.sv
module clk_cfg_tick #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] per_q, per_d, cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    per_d = per_q;
    run_d = run_q;
    cnt_d = cnt_q;
    if (load) begin
      per_d = period;
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = (cnt_q >= per_q - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      per_q <= per_d;
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick = run_q && (cnt_q == '0);
endmodule

// File: rtl/clk_cfg_top.sv
module clk_cfg_top #(
  parameter int FW         = 32,
  parameter int IW         = 8,
  parameter int MAX_N      = 255,
  parameter int STABLE_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply_i,
  input  logic [FW-1:0] req_hz_i,
  input  logic [FW-1:0] src_hz_i,
  input  logic [1:0]    timing_i,
  input  logic [IW-1:0] irq_en_i,
  output logic [1:0]    mode_o,
  output logic [7:0]    div_o,
  output logic          half_rate_o,
  output logic [FW-1:0] bus_hz_o,
  output logic          card_tick_o,
  output logic          clk_stable_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          tmo_recalc_o,
  output logic [IW-1:0] irq_en_o
);
  import clk_cfg_pkg::*;

  localparam int DW = FW + 3;
  localparam int NW = $clog2(MAX_N + 1);
  localparam int PW = NW + 2;
  localparam int SW = $clog2(STABLE_CYC + 1);

  state_e st_q, st_d;

  logic [FW-1:0] hz_q, bus_q, p_bus;
  logic [1:0]    tm_q, tm_p, mode_q, p_mode;
  logic [NW-1:0] div_q, p_div, n_q, n_sat;
  logic          half_q, p_half, stable_q, done_q;
  logic [PW-1:0] p_period;
  logic [FW-1:0] hz_p;
  logic [DW-1:0] src_p;
  logic [IW-1:0] irq_q, irq_save_q;
  logic [SW-1:0] cnt_q;

  logic [DW-1:0] req_x, src_x, four_hz, dv_a, dv_b, dv_q;
  logic          dv_start, dv_done;
  logic          changed, sdr_full, hs_half, ddr_quar, fast, ddr_p, settled;

  assign req_x    = DW'(req_hz_i);
  assign src_x    = DW'(src_hz_i);
  assign four_hz  = req_x << 2;
  assign changed  = apply_i && ((req_hz_i != hz_q) || (timing_i != tm_q));
  assign sdr_full = (timing_i == TM_SDR) && (req_x >= src_x);
  assign hs_half  = (timing_i == TM_HS400) && (req_x >= (src_x >> 1));
  assign ddr_quar = (timing_i != TM_SDR) && (req_x >= (src_x >> 2));
  assign fast     = sdr_full || hs_half || ddr_quar;
  assign ddr_p    = (tm_p != TM_SDR);
  assign settled  = (st_q == ST_SETTLE) && (cnt_q == SW'(STABLE_CYC - 1));

  always_comb begin
    if (dv_q > DW'(MAX_N))   n_sat = NW'(MAX_N);
    else if (dv_q == '0)     n_sat = NW'(1);
    else                     n_sat = dv_q[NW-1:0];
  end

  // Shared serial divider: ceil(src/(4*hz)) first, then floor(src/4)/N.
  assign dv_a     = (st_q == ST_IDLE) ? (src_x + four_hz - 1'b1) : (src_p >> 2);
  assign dv_b     = (st_q == ST_IDLE) ? four_hz : DW'(n_sat);
  assign dv_start = ((st_q == ST_IDLE) && changed && !fast) ||
                    ((st_q == ST_CALC_N) && dv_done);

  clk_cfg_divu #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(dv_start),
    .a(dv_a), .b(dv_b), .q(dv_q), .done(dv_done)
  );

  clk_cfg_tick #(.PW(PW)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(st_q == ST_APPLY),
    .period(p_period), .tick(card_tick_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (changed) st_d = fast ? ST_APPLY : ST_CALC_N;
      ST_CALC_N: if (dv_done) st_d = ST_CALC_B;
      ST_CALC_B: if (dv_done) st_d = ST_APPLY;
      ST_APPLY:  st_d = ST_SETTLE;
      ST_SETTLE: if (settled) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      hz_q       <= '0;
      tm_q       <= '0;
      hz_p       <= '0;
      tm_p       <= '0;
      src_p      <= '0;
      n_q        <= '0;
      p_mode     <= '0;
      p_div      <= '0;
      p_half     <= 1'b0;
      p_bus      <= '0;
      p_period   <= '0;
      mode_q     <= '0;
      div_q      <= '0;
      half_q     <= 1'b0;
      bus_q      <= '0;
      stable_q   <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      irq_q      <= '0;
      irq_save_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= settled;
      if (st_q == ST_IDLE && changed) begin
        hz_p       <= req_hz_i;
        tm_p       <= timing_i;
        src_p      <= src_x;
        irq_save_q <= irq_en_i;
        irq_q      <= '0;
        half_q     <= 1'b0;
        stable_q   <= 1'b0;
        p_half     <= hs_half;
        p_div      <= '0;
        if (sdr_full) begin
          p_mode   <= MD_SDR_FULL;
          p_bus    <= src_hz_i;
          p_period <= PW'(1);
        end else if (hs_half) begin
          p_mode   <= MD_HS400;
          p_bus    <= src_hz_i >> 1;
          p_period <= PW'(2);
        end else if (ddr_quar) begin
          p_mode   <= (timing_i == TM_HS400) ? MD_HS400 : MD_DDR;
          p_bus    <= src_hz_i >> 2;
          p_period <= PW'(4);
        end
      end else if (st_q == ST_IDLE) begin
        irq_q <= irq_en_i;
      end
      if (st_q == ST_CALC_N && dv_done) n_q <= n_sat;
      if (st_q == ST_CALC_B && dv_done) begin
        p_bus    <= dv_q[FW-1:0];
        p_div    <= ddr_p ? (n_q >> 1) : n_q;
        p_mode   <= !ddr_p ? MD_SDR_DIV : ((tm_p == TM_HS400) ? MD_HS400 : MD_DDR);
        p_period <= PW'({n_q, 2'b00});
      end
      if (st_q == ST_APPLY) begin
        mode_q <= p_mode;
        div_q  <= p_div;
        half_q <= p_half;
        bus_q  <= p_bus;
        cnt_q  <= '0;
      end
      if (st_q == ST_SETTLE) begin
        cnt_q <= cnt_q + 1'b1;
        if (settled) begin
          stable_q <= 1'b1;
          irq_q    <= irq_save_q;
          hz_q     <= hz_p;
          tm_q     <= tm_p;
        end
      end
    end
  end

  assign mode_o       = mode_q;
  assign div_o        = 8'(div_q);
  assign half_rate_o  = half_q;
  assign bus_hz_o     = bus_q;
  assign clk_stable_o = stable_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign tmo_recalc_o = done_q;
  assign irq_en_o     = irq_q;
endmodule

// File: rtl/clk_cfg_chk.sv
module clk_cfg_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_o,
  input logic [7:0]    div_o,
  input logic          half_rate_o,
  input logic          card_tick_o,
  input logic          clk_stable_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          tmo_recalc_o,
  input logic [IW-1:0] irq_en_o
);
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (irq_en_o == '0));
  // R8
  busy_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !clk_stable_o);
  // R8
  done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (clk_stable_o && tmo_recalc_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  half_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_rate_o |-> (mode_o == 2'd3 && div_o == 8'd0));
  // R2
  full_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (div_o == 8'd0));
  // R9
  full_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && clk_stable_o) |-> card_tick_o);
endmodule

bind clk_cfg_top clk_cfg_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .div_o(div_o),
  .half_rate_o(half_rate_o), .card_tick_o(card_tick_o),
  .clk_stable_o(clk_stable_o), .busy_o(busy_o), .done_o(done_o),
  .tmo_recalc_o(tmo_recalc_o), .irq_en_o(irq_en_o)
);

// File: tb/sim_clk_cfg_top.sv
module sim_clk_cfg_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 32;
  localparam int IW = 8;
  localparam int STABLE_CYC = 8;
  localparam longint SRC = 100_000_000;

  logic          clk, rst_n, apply_i;
  logic [FW-1:0] req_hz_i, src_hz_i, bus_hz_o;
  logic [1:0]    timing_i, mode_o;
  logic [IW-1:0] irq_en_i, irq_en_o;
  logic [7:0]    div_o;
  logic          half_rate_o, card_tick_o, clk_stable_o, busy_o, done_o, tmo_recalc_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  clk_cfg_top #(.FW(FW), .IW(IW), .STABLE_CYC(STABLE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .apply_i(apply_i), .req_hz_i(req_hz_i),
    .src_hz_i(src_hz_i), .timing_i(timing_i), .irq_en_i(irq_en_i),
    .mode_o(mode_o), .div_o(div_o), .half_rate_o(half_rate_o),
    .bus_hz_o(bus_hz_o), .card_tick_o(card_tick_o), .clk_stable_o(clk_stable_o),
    .busy_o(busy_o), .done_o(done_o), .tmo_recalc_o(tmo_recalc_o), .irq_en_o(irq_en_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // expected setting, from the requirements
  int     e_mode = 0, e_div = 0, e_half = 0;
  longint e_bus = 0, e_per = 0;

  task automatic model(input longint hz, input longint src, input int t);
    longint n;
    e_half = 0; e_div = 0;
    if (t == 0 && hz >= src) begin
      e_mode = 1; e_bus = src; e_per = 1;
    end else if (t == 3 && hz >= (src >> 1)) begin
      e_mode = 3; e_half = 1; e_bus = src >> 1; e_per = 2;
    end else if (t != 0 && hz >= (src >> 2)) begin
      e_mode = (t == 3) ? 3 : 2; e_bus = src >> 2; e_per = 4;
    end else begin
      if (hz == 0) n = 255;
      else n = (src + 4*hz - 1) / (4*hz);
      if (n > 255) n = 255;
      if (n < 1) n = 1;
      e_mode = (t == 0) ? 0 : ((t == 3) ? 3 : 2);
      e_div  = (t == 0) ? int'(n) : int'(n >> 1);
      e_bus  = (src >> 2) / n;
      e_per  = 4 * n;
    end
  endtask

  task automatic measure_tick(input string req);
    int gap = 0;
    int w = 0;
    @(negedge clk);
    while (!card_tick_o && w < 2200) begin w++; @(negedge clk); end
    @(negedge clk); gap = 1;
    while (!card_tick_o && gap < 2200) begin gap++; @(negedge clk); end
    chk(gap == e_per, req, gap, e_per);
  endtask

  task automatic cfg(input longint hz, input int t, input bit change, input string req);
    logic [IW-1:0] snap;
    int lat = 0;
    snap = irq_en_i;
    @(negedge clk);
    req_hz_i = hz[FW-1:0]; timing_i = t[1:0]; apply_i = 1'b1;
    @(negedge clk);
    apply_i = 1'b0;
    if (!change) begin
      for (int i = 0; i < 6; i++) begin
        chk(!busy_o && !done_o, {req, " R1 ignored"}, busy_o, 0);
        chk(mode_o == e_mode && div_o == e_div && bus_hz_o == e_bus,
            {req, " R1 unchanged"}, bus_hz_o, e_bus);
        @(negedge clk);
      end
      return;
    end
    model(hz, SRC, t);
    chk(half_rate_o == 1'b0, {req, " R6 flag cleared"}, half_rate_o, 0);
    irq_en_i = ~snap;
    lat = 1;
    while (!done_o && lat < 200) begin
      chk(busy_o == 1'b1, {req, " R8 busy"}, busy_o, 1);
      chk(irq_en_o == '0, {req, " R7 masked"}, irq_en_o, 0);
      lat++;
      @(negedge clk);
    end
    chk(done_o && lat >= STABLE_CYC + 1, {req, " R8 done latency"}, lat, STABLE_CYC + 1);
    chk(clk_stable_o && tmo_recalc_o, {req, " R8 stable+recalc"}, clk_stable_o, 1);
    chk(irq_en_o == snap, {req, " R7 restored"}, irq_en_o, snap);
    chk(mode_o == e_mode, {req, " mode"}, mode_o, e_mode);
    chk(div_o == e_div, {req, " divider"}, div_o, e_div);
    chk(half_rate_o == e_half, {req, " R6 half"}, half_rate_o, e_half);
    chk(bus_hz_o == e_bus, {req, " bus_hz"}, bus_hz_o, e_bus);
    irq_en_i = snap;
    @(negedge clk);
    chk(!done_o && !tmo_recalc_o, {req, " R8 pulse"}, done_o, 0);
    measure_tick({req, " R9 tick period"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; apply_i = 1'b0; req_hz_i = '0; timing_i = '0;
    src_hz_i = SRC[FW-1:0]; irq_en_i = 8'hA5;
    repeat (3) @(negedge clk);
    // R10
    chk(mode_o == 0 && div_o == 0 && half_rate_o == 0 && bus_hz_o == 0,
        "R10 reset setting", bus_hz_o, 0);
    chk(!clk_stable_o && !card_tick_o && irq_en_o == 0 && !busy_o,
        "R10 reset flags", irq_en_o, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!card_tick_o, "R10 no tick before first setting", card_tick_o, 0);
    cfg(0, 0, 0, "R1 R10 stored zero");
    cfg(100_000_000, 0, 1, "R2 full rate");
    cfg(100_000_000, 0, 0, "R1 repeat");
    cfg(400_000, 0, 1, "R3 divided");
    cfg(1000, 0, 1, "R3 saturate");
    cfg(50_000_000, 1, 1, "R4 ddr quarter");
    cfg(10_000_000, 2, 1, "R5 ddr divided");
    cfg(10_000_000, 1, 1, "R1 R5 timing only");
    cfg(200_000_000, 3, 1, "R6 half rate");
    cfg(30_000_000, 3, 1, "R4 R6 hs quarter");
    cfg(6_000_000, 3, 1, "R5 hs divided");
    cfg(0, 0, 1, "R3 zero request");
    finish_run();
  end
endmodule